// File: doc/BRIEF.md
# Serial Flash Buffered Page Program Front-End

This block is the device-side command front-end of a serial flash that has two page buffers. While chip select is low it assembles bytes from the serial input. It recognises two program-through-buffer opcodes, each followed by a 24-bit address. The data bytes that come after the address are written into the selected buffer, starting at the addressed byte and wrapping at the buffer end. When chip select rises after a complete command, a self-timed sequencer erases the addressed page of an internal page store to all ones and then copies the buffer into it. The busy output is high for the whole of that interval.

The page layout is chosen by a mode input, either 264-byte or 256-byte pages. A separate four-byte sequence erases the entire store. A write-protect input is latched into a protect flag only while the block is idle, and that flag blocks any new erase or program. The serial pins are synchronised into the system clock domain. A read port onto the page store lets the surrounding logic observe the programmed contents.

Top module: `sflash_pgm_front`

## Requirements
- R1: Serial bytes are taken most-significant bit first, one bit per rising SCK edge while CS is low. The bit count restarts whenever CS is high.
- R2: Opcode 0x82 selects buffer 0 and 0x85 selects buffer 1. Either opcode is followed by three address bytes. Any other opcode writes no buffer and starts no operation.
- R3: In 264-byte mode the address bits [20:9] are the page and bits [8:0] are the starting buffer byte. A start of 264 or more wraps modulo 264, and bits [23:21] are ignored.
- R4: In 256-byte mode the address bits [19:8] are the page and bits [7:0] are the starting buffer byte. Bits [23:20] are ignored.
- R5: Data bytes go to consecutive buffer locations. After byte 263 (264-byte mode) or byte 255 (256-byte mode) the next location is byte 0.
- R6: When CS rises after a complete program command, the page selected by the page address modulo NUM_PAGES is first set to 0xFF in all 264 bytes. Buffer bytes 0 through size-1 are then copied into it, so in 256-byte mode bytes 256 to 263 end as 0xFF. A command with no data bytes programs the existing buffer contents.
- R7: busy_o is high for exactly BUSY_CYC clock cycles for a page program and exactly CHIP_CYC cycles for a chip erase.
- R8: Exactly the four bytes 0xC7, 0x94, 0x80, 0x9A followed by a CS rise set every byte of the store to 0xFF. A different fourth byte, or a fifth byte, starts nothing.
- R9: If CS rises in the middle of a byte, or before the third address byte has arrived, no program starts. Data bytes that were already complete stay in the buffer.
- R10: A command any byte of which arrives while busy_o is high is discarded entirely: it writes no buffer byte and starts no operation.
- R11: prot_o follows wp_i only while the block is idle. It holds its value for the whole of a busy interval and takes the new wp_i value after busy_o falls.
- R12: While prot_o is high, program and chip-erase commands start nothing, but the data bytes are still written into the buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Serial chip select, active low |
| sck_i | input | 1 | Serial clock |
| si_i | input | 1 | Serial data in |
| page264_i | input | 1 | 1 = 264-byte page layout, 0 = 256-byte layout |
| wp_i | input | 1 | Write-protect request |
| busy_o | output | 1 | Erase/program sequence in progress |
| prot_o | output | 1 | Protection in effect |
| rd_page_i | input | $clog2(NUM_PAGES) | Page store read page |
| rd_byte_i | input | 9 | Page store read byte, 0 to 263 |
| rd_data_o | output | 8 | Page store read data |

## Verification
Two events can overlap in time. The first is a write-protect change arriving while an erase/program sequence is running. The second is a new command arriving on the serial pins while the block is still busy. The bench raises wp_i part-way through a busy interval and checks that prot_o stays low until busy_o has fallen and rises only afterwards. It also sends a second complete program command during a busy interval, then checks that the target page is untouched and that a later zero-length program of the second buffer shows its old contents, which proves that the ignored data never reached the buffer.

// File: rtl/sflash_pkg.sv
package sflash_pkg;
  localparam int PAGE_BYTES = 264;
  localparam int BIN_BYTES  = 256;
  localparam int BUF_AW     = 9;

  localparam logic [7:0] OP_PROG_B0 = 8'h82;
  localparam logic [7:0] OP_PROG_B1 = 8'h85;
  localparam logic [7:0] CE_B0 = 8'hC7;
  localparam logic [7:0] CE_B1 = 8'h94;
  localparam logic [7:0] CE_B2 = 8'h80;
  localparam logic [7:0] CE_B3 = 8'h9A;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ERASE,
    ST_PROG,
    ST_HOLD
  } seq_st_e;
endpackage

// File: rtl/sflash_spi_rx.sv
module sflash_spi_rx #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       si_i,
  output logic       byte_vld_o,
  output logic [7:0] byte_o,
  output logic       cs_rise_o,
  output logic       mid_byte_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] cs_s, sck_s, si_s;
  logic       cs_d, sck_d;
  logic [2:0] bit_q;
  logic [6:0] sh_q;
  logic       cs_hi, sck_rise;

  assign cs_hi    = cs_s[TOP];
  assign sck_rise = sck_s[TOP] & ~sck_d & ~cs_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_s       <= '1;
      sck_s      <= '0;
      si_s       <= '0;
      cs_d       <= 1'b1;
      sck_d      <= 1'b0;
      bit_q      <= '0;
      sh_q       <= '0;
      byte_vld_o <= 1'b0;
      byte_o     <= '0;
    end else begin
      cs_s       <= {cs_s[SYNC_STAGES-2:0], cs_ni};
      sck_s      <= {sck_s[SYNC_STAGES-2:0], sck_i};
      si_s       <= {si_s[SYNC_STAGES-2:0], si_i};
      cs_d       <= cs_hi;
      sck_d      <= sck_s[TOP];
      byte_vld_o <= 1'b0;
      if (cs_hi) begin
        bit_q <= '0;
      end else if (sck_rise) begin
        bit_q <= bit_q + 3'd1;
        sh_q  <= {sh_q[5:0], si_s[TOP]};
        if (bit_q == 3'd7) begin
          byte_vld_o <= 1'b1;
          byte_o     <= {sh_q, si_s[TOP]};
        end
      end
    end
  end

  assign cs_rise_o  = cs_hi & ~cs_d;
  assign mid_byte_o = (bit_q != 3'd0);
endmodule

// File: rtl/sflash_cmd_dec.sv
module sflash_cmd_dec
  import sflash_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic [7:0]        byte_i,
  input  logic              cs_rise_i,
  input  logic              mid_byte_i,
  input  logic              page264_i,
  input  logic              busy_i,
  input  logic              prot_i,
  output logic              buf_we_o,
  output logic              buf_sel_o,
  output logic [BUF_AW-1:0] buf_addr_o,
  output logic [7:0]        buf_data_o,
  output logic              launch_o,
  output logic              launch_chip_o,
  output logic [11:0]       launch_page_o,
  output logic              mode264_o
);
  logic [2:0]        cnt_q;
  logic [7:0]        op_q;
  logic [20:0]       addr_q;
  logic [BUF_AW-1:0] ptr_q;
  logic              mode_q, blocked_q, ce_ok_q;
  logic              is_prog, prog_ok, chip_ok, ce_hit;
  logic [20:0]       addr_n;
  logic [BUF_AW-1:0] start_n, ptr_inc, buf_last;

  assign is_prog  = (op_q == OP_PROG_B0) || (op_q == OP_PROG_B1);
  assign addr_n   = {addr_q[12:0], byte_i};
  assign buf_last = mode_q ? BUF_AW'(PAGE_BYTES - 1) : BUF_AW'(BIN_BYTES - 1);
  assign ptr_inc  = (ptr_q == buf_last) ? '0 : ptr_q + 1'b1;

  always_comb begin
    if (page264_i) begin
      start_n = addr_n[8:0];
      if (start_n >= BUF_AW'(PAGE_BYTES)) start_n = start_n - BUF_AW'(PAGE_BYTES);
    end else begin
      start_n = {1'b0, addr_n[7:0]};
    end
  end

  always_comb begin
    case (cnt_q)
      3'd0:    ce_hit = (byte_i == CE_B0);
      3'd1:    ce_hit = ce_ok_q && (byte_i == CE_B1);
      3'd2:    ce_hit = ce_ok_q && (byte_i == CE_B2);
      3'd3:    ce_hit = ce_ok_q && (byte_i == CE_B3);
      default: ce_hit = ce_ok_q;
    endcase
  end

  assign buf_we_o   = byte_vld_i && (cnt_q >= 3'd4) && is_prog && !blocked_q && !busy_i;
  assign buf_sel_o  = (op_q == OP_PROG_B1);
  assign buf_addr_o = ptr_q;
  assign buf_data_o = byte_i;

  assign prog_ok       = is_prog && (cnt_q >= 3'd4);
  assign chip_ok       = ce_ok_q && (cnt_q == 3'd4);
  assign launch_o      = cs_rise_i && !mid_byte_i && (prog_ok || chip_ok)
                         && !blocked_q && !busy_i && !prot_i;
  assign launch_chip_o = chip_ok;
  assign launch_page_o = mode_q ? addr_q[20:9] : addr_q[19:8];
  assign mode264_o     = mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      op_q      <= '0;
      addr_q    <= '0;
      ptr_q     <= '0;
      mode_q    <= 1'b1;
      blocked_q <= 1'b0;
      ce_ok_q   <= 1'b0;
    end else if (cs_rise_i) begin
      cnt_q     <= '0;
      op_q      <= '0;
      blocked_q <= 1'b0;
      ce_ok_q   <= 1'b0;
    end else if (byte_vld_i) begin
      if (cnt_q != 3'd7) cnt_q <= cnt_q + 3'd1;
      if (busy_i) blocked_q <= 1'b1;
      ce_ok_q <= ce_hit;
      if (cnt_q == 3'd0) op_q <= byte_i;
      if (cnt_q >= 3'd1 && cnt_q <= 3'd3) addr_q <= addr_n;
      if (cnt_q == 3'd3) begin
        ptr_q  <= start_n;
        mode_q <= page264_i;
      end
      if (buf_we_o) ptr_q <= ptr_inc;
    end
  end
endmodule

// File: rtl/sflash_page_buf.sv
module sflash_page_buf
  import sflash_pkg::*;
#(
  parameter int NUM_BUF = 2
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [BUF_AW-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              rd_sel_i,
  input  logic [BUF_AW-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [7:0] rd_arr [NUM_BUF];

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_buf
    logic [7:0] mem_q [PAGE_BYTES];
    always_ff @(posedge clk_i) begin
      if (we_i && (32'(sel_i) == b)) mem_q[addr_i] <= data_i;
    end
    assign rd_arr[b] = mem_q[rd_addr_i];
  end

  assign rd_data_o = rd_arr[rd_sel_i];
endmodule

// File: rtl/sflash_array.sv
module sflash_array
  import sflash_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  parameter int BUSY_CYC  = 600,
  parameter int CHIP_CYC  = 1200,
  localparam int PG_W    = $clog2(NUM_PAGES),
  localparam int MEM_N   = NUM_PAGES * PAGE_BYTES,
  localparam int MA_W    = $clog2(MEM_N),
  localparam int MAX_CYC = (CHIP_CYC > BUSY_CYC) ? CHIP_CYC : BUSY_CYC,
  localparam int CYC_W   = $clog2(MAX_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              launch_i,
  input  logic              chip_i,
  input  logic [11:0]       page_i,
  input  logic              buf_i,
  input  logic              mode264_i,
  output logic              busy_o,
  output logic              buf_rd_sel_o,
  output logic [BUF_AW-1:0] buf_rd_addr_o,
  input  logic [7:0]        buf_rd_data_i,
  input  logic [PG_W-1:0]   rd_page_i,
  input  logic [BUF_AW-1:0] rd_byte_i,
  output logic [7:0]        rd_data_o
);
  seq_st_e          st_q;
  logic [CYC_W-1:0] cyc_q, lim_m1;
  logic [MA_W-1:0]  idx_q, base_q, base_n, waddr, raddr;
  logic             chip_q, bsel_q, mode_q;
  logic             erase_end, prog_end, mem_we;
  logic [7:0]       wdata;
  logic [11:0]      pg_mod;
  logic [7:0]       mem_q [MEM_N];

  assign pg_mod    = page_i % 12'(NUM_PAGES);
  assign base_n    = MA_W'(32'(pg_mod) * PAGE_BYTES);
  assign lim_m1    = chip_q ? CYC_W'(CHIP_CYC - 1) : CYC_W'(BUSY_CYC - 1);
  assign erase_end = idx_q == (chip_q ? MA_W'(MEM_N - 1) : MA_W'(PAGE_BYTES - 1));
  assign prog_end  = idx_q == (mode_q ? MA_W'(PAGE_BYTES - 1) : MA_W'(BIN_BYTES - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cyc_q  <= '0;
      idx_q  <= '0;
      base_q <= '0;
      chip_q <= 1'b0;
      bsel_q <= 1'b0;
      mode_q <= 1'b1;
    end else if (st_q == ST_IDLE) begin
      if (launch_i) begin
        st_q   <= ST_ERASE;
        cyc_q  <= '0;
        idx_q  <= '0;
        chip_q <= chip_i;
        bsel_q <= buf_i;
        mode_q <= mode264_i;
        base_q <= chip_i ? '0 : base_n;
      end
    end else begin
      cyc_q <= cyc_q + 1'b1;
      if (cyc_q == lim_m1) begin
        st_q <= ST_IDLE;
      end else if (st_q == ST_ERASE) begin
        if (erase_end) begin
          idx_q <= '0;
          st_q  <= chip_q ? ST_HOLD : ST_PROG;
        end else begin
          idx_q <= idx_q + 1'b1;
        end
      end else if (st_q == ST_PROG) begin
        if (prog_end) st_q <= ST_HOLD;
        else          idx_q <= idx_q + 1'b1;
      end
    end
  end

  // erase sweep writes 0xFF, program sweep copies the buffer
  assign mem_we = (st_q == ST_ERASE) || (st_q == ST_PROG);
  assign waddr  = base_q + idx_q;
  assign wdata  = (st_q == ST_ERASE) ? 8'hFF : buf_rd_data_i;

  always_ff @(posedge clk_i) begin
    if (mem_we) mem_q[waddr] <= wdata;
  end

  assign buf_rd_sel_o  = bsel_q;
  assign buf_rd_addr_o = idx_q[BUF_AW-1:0];
  assign busy_o        = (st_q != ST_IDLE);
  assign raddr         = MA_W'(32'(rd_page_i) * PAGE_BYTES + 32'(rd_byte_i));
  assign rd_data_o     = mem_q[raddr];
endmodule

// File: rtl/sflash_pgm_front.sv
module sflash_pgm_front
  import sflash_pkg::*;
#(
  parameter int NUM_PAGES   = 4,
  parameter int BUSY_CYC    = 600,
  parameter int CHIP_CYC    = 1200,
  parameter int SYNC_STAGES = 2,
  localparam int PG_W = $clog2(NUM_PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            sck_i,
  input  logic            si_i,
  input  logic            page264_i,
  input  logic            wp_i,
  output logic            busy_o,
  output logic            prot_o,
  input  logic [PG_W-1:0] rd_page_i,
  input  logic [8:0]      rd_byte_i,
  output logic [7:0]      rd_data_o
);
  logic              byte_vld_w, cs_rise_w, mid_byte_w;
  logic [7:0]        byte_w;
  logic              buf_we_w, buf_sel_w, launch_w, launch_chip_w, mode_w;
  logic [BUF_AW-1:0] buf_addr_w, buf_rd_addr_w;
  logic [7:0]        buf_data_w, buf_rd_data_w;
  logic [11:0]       launch_page_w;
  logic              buf_rd_sel_w, busy_w, prot_q;

  sflash_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) i_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .sck_i      (sck_i),
    .si_i       (si_i),
    .byte_vld_o (byte_vld_w),
    .byte_o     (byte_w),
    .cs_rise_o  (cs_rise_w),
    .mid_byte_o (mid_byte_w)
  );

  sflash_cmd_dec i_dec (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .byte_vld_i    (byte_vld_w),
    .byte_i        (byte_w),
    .cs_rise_i     (cs_rise_w),
    .mid_byte_i    (mid_byte_w),
    .page264_i     (page264_i),
    .busy_i        (busy_w),
    .prot_i        (prot_q),
    .buf_we_o      (buf_we_w),
    .buf_sel_o     (buf_sel_w),
    .buf_addr_o    (buf_addr_w),
    .buf_data_o    (buf_data_w),
    .launch_o      (launch_w),
    .launch_chip_o (launch_chip_w),
    .launch_page_o (launch_page_w),
    .mode264_o     (mode_w)
  );

  sflash_page_buf #(.NUM_BUF(2)) i_buf (
    .clk_i     (clk_i),
    .we_i      (buf_we_w),
    .sel_i     (buf_sel_w),
    .addr_i    (buf_addr_w),
    .data_i    (buf_data_w),
    .rd_sel_i  (buf_rd_sel_w),
    .rd_addr_i (buf_rd_addr_w),
    .rd_data_o (buf_rd_data_w)
  );

  sflash_array #(
    .NUM_PAGES (NUM_PAGES),
    .BUSY_CYC  (BUSY_CYC),
    .CHIP_CYC  (CHIP_CYC)
  ) i_array (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .launch_i      (launch_w),
    .chip_i        (launch_chip_w),
    .page_i        (launch_page_w),
    .buf_i         (buf_sel_w),
    .mode264_i     (mode_w),
    .busy_o        (busy_w),
    .buf_rd_sel_o  (buf_rd_sel_w),
    .buf_rd_addr_o (buf_rd_addr_w),
    .buf_rd_data_i (buf_rd_data_w),
    .rd_page_i     (rd_page_i),
    .rd_byte_i     (rd_byte_i),
    .rd_data_o     (rd_data_o)
  );

  // protect flag only moves while the sequencer is idle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  prot_q <= 1'b0;
    else if (!busy_w && !launch_w) prot_q <= wp_i;
  end

  assign busy_o = busy_w;
  assign prot_o = prot_q;
endmodule

// File: rtl/sflash_pgm_front_chk.sv
module sflash_pgm_front_chk #(
  parameter int BUSY_CYC = 600,
  parameter int CHIP_CYC = 1200
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       prot_o,
  input logic       launch_i,
  input logic       buf_we_i,
  input logic [8:0] buf_addr_i,
  input logic       buf_mode_i
);
  logic [15:0] len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     len_q <= '0;
    else if (busy_o) len_q <= len_q + 16'd1;
    else             len_q <= '0;
  end

  AST_BUSY_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (32'(len_q) == BUSY_CYC || 32'(len_q) == CHIP_CYC)); // R7
  AST_LAUNCH_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |=> busy_o); // R7
  AST_LAUNCH_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !busy_o); // R10
  AST_BUF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |-> !busy_o); // R10
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_i |-> (buf_addr_i < (buf_mode_i ? 9'd264 : 9'd256))); // R5
  AST_PROT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(prot_o)); // R11
  AST_PROT_BLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    launch_i |-> !prot_o); // R12
endmodule

bind sflash_pgm_front sflash_pgm_front_chk #(
  .BUSY_CYC (BUSY_CYC),
  .CHIP_CYC (CHIP_CYC)
) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .prot_o     (prot_o),
  .launch_i   (launch_w),
  .buf_we_i   (buf_we_w),
  .buf_addr_i (buf_addr_w),
  .buf_mode_i (mode_w)
);

// File: tb/test_sflash_pgm_front.sv
module test_sflash_pgm_front;
  localparam int NP    = 4;
  localparam int BUSY  = 600;
  localparam int CHIP  = 1200;
  localparam int PB    = 264;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, p264 = 1'b1, wp = 1'b0;
  logic busy, prot;
  logic [1:0] rd_page = '0;
  logic [8:0] rd_byte = '0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  logic [7:0] mdl_mem [NP][PB];
  logic [7:0] mdl_buf [2][PB];

  always #2 clk = ~clk;

  sflash_pgm_front #(.NUM_PAGES(NP), .BUSY_CYC(BUSY), .CHIP_CYC(CHIP)) i_sflash_pgm_front (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si),
    .page264_i(p264), .wp_i(wp), .busy_o(busy), .prot_o(prot),
    .rd_page_i(rd_page), .rd_byte_i(rd_byte), .rd_data_o(rd_data)
  );

  typedef struct packed {
    logic       m264;
    logic       bsel;
    logic [11:0] page;
    logic [8:0] start;
    logic [9:0] nbytes;
    logic [7:0] seed;
  } vec_t;

  // R1 R3 R4 R5 R6 R7: fills, wraps at 264 and 256, start>=264, page modulo, zero-length
  localparam vec_t VECS [6] = '{
    '{1'b1, 1'b0, 12'd1, 9'd0,   10'd264, 8'h11},
    '{1'b1, 1'b1, 12'd2, 9'd0,   10'd264, 8'h40},
    '{1'b1, 1'b0, 12'd3, 9'd260, 10'd10,  8'hA0},
    '{1'b0, 1'b1, 12'd0, 9'd250, 10'd12,  8'h05},
    '{1'b1, 1'b1, 12'd5, 9'd300, 10'd4,   8'h77},
    '{1'b0, 1'b0, 12'd2, 9'd0,   10'd0,   8'h00}
  };

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_bits(logic [7:0] b, int nb);
    for (int i = 7; i > 7 - nb; i--) begin
      si = b[i];
      wclk(2);
      sck = 1'b1;
      wclk(2);
      sck = 1'b0;
    end
  endtask

  task automatic spi_byte(logic [7:0] b);
    spi_bits(b, 8);
  endtask

  task automatic cs_lo();
    cs_n = 1'b0;
    wclk(2);
  endtask

  task automatic cs_hi(int window, output int w);
    wclk(2);
    cs_n = 1'b1;
    w = 0;
    repeat (window) begin
      @(negedge clk);
      if (busy) w++;
    end
  endtask

  task automatic send_addr(bit m264, int page, int start);
    logic [23:0] a;
    if (m264) a = {3'b0, 12'(page), 9'(start)};
    else      a = {4'b0, 12'(page), 8'(start)};
    spi_byte(a[23:16]);
    spi_byte(a[15:8]);
    spi_byte(a[7:0]);
  endtask

  // opcode, address and data; the model buffer follows when upd is set
  task automatic send_prog(bit m264, bit bsel, int page, int start, int n,
                           logic [7:0] seed, bit upd);
    int ptr, size;
    p264 = m264;
    cs_lo();
    spi_byte(bsel ? 8'h85 : 8'h82);
    send_addr(m264, page, start);
    size = m264 ? 264 : 256;
    ptr  = m264 ? start % 264 : start;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = seed + 8'(k * 3);
      spi_byte(d);
      if (upd) mdl_buf[bsel][ptr] = d;
      ptr = (ptr + 1) % size;
    end
  endtask

  task automatic mdl_program(int page, bit bsel, bit m264);
    int pp;
    pp = page % NP;
    for (int b = 0; b < PB; b++) mdl_mem[pp][b] = 8'hFF;
    for (int b = 0; b < (m264 ? 264 : 256); b++) mdl_mem[pp][b] = mdl_buf[bsel][b];
  endtask

  task automatic check_page(int pp, string req);
    int bad, act, exp;
    bad = 0; act = 0; exp = 0;
    for (int b = 0; b < PB; b++) begin
      rd_page = 2'(pp);
      rd_byte = 9'(b);
      #1;
      if (rd_data !== mdl_mem[pp][b]) begin
        if (bad == 0) begin
          act = int'(rd_data);
          exp = int'(mdl_mem[pp][b]);
        end
        bad++;
      end
    end
    chk(bad == 0, req, act, exp);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int w;
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    chk(busy == 1'b0, "R7 reset busy", int'(busy), 0);
    chk(prot == 1'b0, "R11 reset prot", int'(prot), 0);

    // R8 chip erase
    cs_lo();
    spi_byte(8'hC7); spi_byte(8'h94); spi_byte(8'h80); spi_byte(8'h9A);
    cs_hi(CHIP + 60, w);
    chk(w == CHIP, "R7 R8 chip busy length", w, CHIP);
    for (int p = 0; p < NP; p++) begin
      for (int b = 0; b < PB; b++) mdl_mem[p][b] = 8'hFF;
      check_page(p, "R8 chip erase page");
    end

    for (int v = 0; v < 6; v++) begin
      send_prog(VECS[v].m264, VECS[v].bsel, int'(VECS[v].page), int'(VECS[v].start),
                int'(VECS[v].nbytes), VECS[v].seed, 1'b1);
      cs_hi(BUSY + 60, w);
      chk(w == BUSY, "R7 program busy length", w, BUSY);
      mdl_program(int'(VECS[v].page), VECS[v].bsel, VECS[v].m264);
      check_page(int'(VECS[v].page) % NP, "R1 R3 R4 R5 R6 vector page");
    end

    // R8 wrong fourth byte, and a fifth byte
    cs_lo();
    spi_byte(8'hC7); spi_byte(8'h94); spi_byte(8'h80); spi_byte(8'h9B);
    cs_hi(60, w);
    chk(w == 0, "R8 wrong sequence", w, 0);
    cs_lo();
    spi_byte(8'hC7); spi_byte(8'h94); spi_byte(8'h80); spi_byte(8'h9A); spi_byte(8'h00);
    cs_hi(60, w);
    chk(w == 0, "R8 extra byte", w, 0);
    check_page(0, "R8 page untouched");

    // R2 unknown opcode writes nothing
    p264 = 1'b1;
    cs_lo();
    spi_byte(8'h83);
    send_addr(1'b1, 2, 0);
    spi_byte(8'h5A); spi_byte(8'h5B);
    cs_hi(60, w);
    chk(w == 0, "R2 unknown opcode", w, 0);

    // R9 cut mid-byte: completed data byte stays in buffer
    send_prog(1'b1, 1'b0, 2, 5, 1, 8'hAB, 1'b1);
    spi_bits(8'hFF, 3);
    cs_hi(60, w);
    chk(w == 0, "R9 mid-byte abort", w, 0);
    // R9 short address
    cs_lo();
    spi_byte(8'h82); spi_byte(8'h00); spi_byte(8'h04);
    cs_hi(60, w);
    chk(w == 0, "R9 short address", w, 0);
    send_prog(1'b1, 1'b0, 2, 0, 0, 8'h00, 1'b1);
    cs_hi(BUSY + 60, w);
    chk(w == BUSY, "R9 R2 follow-up busy", w, BUSY);
    mdl_program(2, 1'b0, 1'b1);
    check_page(2, "R2 R9 buffer contents");

    // R10 command during busy
    send_prog(1'b1, 1'b0, 0, 0, 2, 8'h61, 1'b1);
    cs_hi(30, w);
    send_prog(1'b1, 1'b1, 3, 0, 5, 8'hEE, 1'b0);
    cs_hi(BUSY + 60, w);
    mdl_program(0, 1'b0, 1'b1);
    check_page(0, "R10 first program");
    check_page(3, "R10 ignored program page");
    send_prog(1'b1, 1'b1, 3, 0, 0, 8'h00, 1'b1);
    cs_hi(BUSY + 60, w);
    mdl_program(3, 1'b1, 1'b1);
    check_page(3, "R10 ignored buffer write");

    // R11 wp raised while busy; R12 blocking
    send_prog(1'b1, 1'b1, 1, 0, 1, 8'h3C, 1'b1);
    cs_hi(20, w);
    wp = 1'b1;
    wclk(20);
    chk(busy == 1'b1 && prot == 1'b0, "R11 prot held while busy", int'(prot), 0);
    wclk(BUSY + 40);
    chk(busy == 1'b0 && prot == 1'b1, "R11 prot after busy", int'(prot), 1);
    mdl_program(1, 1'b1, 1'b1);
    check_page(1, "R11 program completed");
    cs_lo();
    spi_byte(8'hC7); spi_byte(8'h94); spi_byte(8'h80); spi_byte(8'h9A);
    cs_hi(60, w);
    chk(w == 0, "R12 chip erase blocked", w, 0);
    send_prog(1'b1, 1'b0, 3, 0, 3, 8'h90, 1'b1);
    cs_hi(60, w);
    chk(w == 0, "R12 program blocked", w, 0);
    wp = 1'b0;
    wclk(5);
    chk(prot == 1'b0, "R11 prot release", int'(prot), 0);
    send_prog(1'b1, 1'b0, 3, 0, 0, 8'h00, 1'b1);
    cs_hi(BUSY + 60, w);
    mdl_program(3, 1'b0, 1'b1);
    check_page(3, "R12 buffer written while protected");

    summary();
    $finish;
  end
endmodule